// File: doc/BRIEF.md
# Double-Buffered PWM Timer

An up-counting timer with a prescaler, a period register and a set of compare channels, each driving one PWM output. Every timing value exists twice. Software writes and reads a staged copy. A working copy, which software cannot see, is what the prescaler, the counter and the comparators actually use.

Working copies take the staged values together, in one clock cycle, at an update event. An update event happens when the counter wraps. Software can also force one at any time. Because all working copies change at once, a new period and new duty cycles on several channels always take effect on the same count.

Per-register buffer bits let the period and each compare value bypass this staging and act at once. The prescaler value is always staged. A sticky update flag reports update events. An enable input gates counting.

Top module: `dbuf_pwm_timer`

## Requirements
- R1: After reset, all staged registers, the control register and the update flag read 0. With the counter at 0 and compare values of 0, every PWM output is low.
- R2: Register map: control at 0, flag at 1, event at 2, prescaler at 3, period at 4, and compare channel c at 5+c.
  - Reading the prescaler, period, compare or control address returns the last written value.
  - Reading the event address always returns 0.
- R3: When control bit 0 (period buffering) is 0, a period write takes effect at once. The counter then runs 0 to P and wraps, giving P+1 counts. If the count already exceeds the new period, the counter wraps on the next tick.
- R4: When control bit 0 is 1, a written period has no effect until the next update event.
- R5: Compare buffering is set per channel by control bit 1+c. When that bit is 0, a compare write acts at once. When it is 1, the old working value stays in force until the next update event.
- R6: On an update event, the prescaler, the period and every buffered compare channel all load their staged values in the same clock cycle.
- R7: A counter tick with the count at or above the effective period wraps the count to 0. The same tick raises an update event and sets the update flag.
- R8: The counter advances once every S+1 enabled clocks, where S is the working prescaler value. S is loaded only at an update event.
- R9: Writing 1 to bit 0 of the event register forces an update event. This event commits all staged values, sets the flag, and clears both the count and the prescaler count.
- R10: The update flag is readable as bit 0 of the flag register. It stays set until software writes a value with bit 0 equal to 0 there. Writing bit 0 as 1 leaves it unchanged.
- R11: The PWM output of channel c is high exactly while the count is below that channel's effective compare value.
- R12: While the enable input is low, the count and the prescaler count hold their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| en_i | input | 1 | Count enable |
| bus_we_i | input | 1 | Register write strobe |
| bus_addr_i | input | ADDR_W | Register address for reads and writes |
| bus_wdata_i | input | CNT_W | Write data |
| bus_rdata_o | output | CNT_W | Read data for bus_addr_i |
| pwm_o | output | NUM_CH | PWM output per compare channel |
| upd_flag_o | output | 1 | Sticky update flag |

## Verification
The bench first measures, with the counter stopped, what the comparators see right after staged compare writes. A design that leaks a buffered compare value, or delays an unbuffered one, shows a wrong output level here.

It then counts PWM high cycles over windows that span the old period and then the new one. A design that commits the period early, or does not commit the compare value in the same cycle, gives the wrong high count in one of those windows.

The prescaler value is changed between update events. Windows measured before and after the next wrap catch a prescaler that takes effect immediately.

A forced update in the middle of a divided count must restart both counters. A design that leaves the prescaler count running shortens the first high stretch. The flag is written with 1 and then with 0, to catch a flag that clears on any write.

// File: rtl/dbuf_pwm_pkg.sv
package dbuf_pwm_pkg;
  localparam int unsigned ADDR_CTRL = 0;
  localparam int unsigned ADDR_FLAG = 1;
  localparam int unsigned ADDR_EVT  = 2;
  localparam int unsigned ADDR_PSC  = 3;
  localparam int unsigned ADDR_PRD  = 4;
  localparam int unsigned ADDR_CMP0 = 5;

  typedef struct packed {
    logic ovf;  // wrap-driven update
    logic upd;  // any update event (wrap or forced)
  } tmr_evt_t;
endpackage

// File: rtl/dbuf_regs.sv
module dbuf_regs
  import dbuf_pwm_pkg::*;
#(
  parameter int unsigned DW     = 16,
  parameter int unsigned NUM_CH = 2,
  parameter int unsigned AW     = 4
) (
  input  logic                       clk_i,
  input  logic                       rst_ni,
  input  logic                       we_i,
  input  logic [AW-1:0]              addr_i,
  input  logic [DW-1:0]              wdata_i,
  output logic [DW-1:0]              rdata_o,
  input  logic                       upd_i,
  output logic                       ug_o,
  output logic                       flag_o,
  output logic                       prd_buf_o,
  output logic [NUM_CH-1:0]          cmp_buf_o,
  output logic [DW-1:0]              psc_pre_o,
  output logic [DW-1:0]              prd_pre_o,
  output logic [NUM_CH-1:0][DW-1:0]  cmp_pre_o
);
  localparam int unsigned CTRL_W = NUM_CH + 1;

  logic [CTRL_W-1:0]         ctrl_q;
  logic [DW-1:0]             psc_q, prd_q;
  logic [NUM_CH-1:0][DW-1:0] cmp_q;
  logic                      flag_q;
  logic                      wr_ctrl, wr_flag, wr_psc, wr_prd;

  assign wr_ctrl = we_i && (addr_i == AW'(ADDR_CTRL));
  assign wr_flag = we_i && (addr_i == AW'(ADDR_FLAG));
  assign wr_psc  = we_i && (addr_i == AW'(ADDR_PSC));
  assign wr_prd  = we_i && (addr_i == AW'(ADDR_PRD));
  assign ug_o    = we_i && (addr_i == AW'(ADDR_EVT)) && wdata_i[0];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ctrl_q <= '0;
      psc_q  <= '0;
      prd_q  <= '0;
      cmp_q  <= '0;
    end else begin
      if (wr_ctrl) ctrl_q <= wdata_i[CTRL_W-1:0];
      if (wr_psc)  psc_q  <= wdata_i;
      if (wr_prd)  prd_q  <= wdata_i;
      for (int c = 0; c < NUM_CH; c++)
        if (we_i && (addr_i == AW'(ADDR_CMP0 + c))) cmp_q[c] <= wdata_i;
    end
  end

  // set wins over a same-cycle clear
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                     flag_q <= 1'b0;
    else if (upd_i)                  flag_q <= 1'b1;
    else if (wr_flag && !wdata_i[0]) flag_q <= 1'b0;
  end

  always_comb begin
    rdata_o = '0;
    if      (addr_i == AW'(ADDR_CTRL)) rdata_o = DW'(ctrl_q);
    else if (addr_i == AW'(ADDR_FLAG)) rdata_o = DW'(flag_q);
    else if (addr_i == AW'(ADDR_PSC))  rdata_o = psc_q;
    else if (addr_i == AW'(ADDR_PRD))  rdata_o = prd_q;
    for (int c = 0; c < NUM_CH; c++)
      if (addr_i == AW'(ADDR_CMP0 + c)) rdata_o = cmp_q[c];
  end

  assign flag_o    = flag_q;
  assign prd_buf_o = ctrl_q[0];
  assign cmp_buf_o = ctrl_q[CTRL_W-1:1];
  assign psc_pre_o = psc_q;
  assign prd_pre_o = prd_q;
  assign cmp_pre_o = cmp_q;

  a_r10_clear_needs_zero_write: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(flag_q) |-> $past(wr_flag && !wdata_i[0]));
  a_r9_update_sets_flag: assert property (@(posedge clk_i) disable iff (!rst_ni)
    upd_i |=> flag_q);
endmodule

// File: rtl/dbuf_counter.sv
module dbuf_counter
  import dbuf_pwm_pkg::*;
#(
  parameter int unsigned CW = 16
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          en_i,
  input  logic          ug_i,
  input  logic          prd_buf_i,
  input  logic [CW-1:0] psc_pre_i,
  input  logic [CW-1:0] prd_pre_i,
  output logic [CW-1:0] cnt_o,
  output tmr_evt_t      evt_o
);
  logic [CW-1:0] psc_sh_q, psc_cnt_q, prd_sh_q, cnt_q, prd_eff;
  logic          tick, ovf, upd;

  assign prd_eff = prd_buf_i ? prd_sh_q : prd_pre_i;
  assign tick    = en_i && (psc_cnt_q >= psc_sh_q);
  // >= lets an unbuffered shrink below the count wrap on the next tick
  assign ovf     = tick && (cnt_q >= prd_eff);
  assign upd     = ovf || ug_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      psc_sh_q  <= '0;
      prd_sh_q  <= '0;
      psc_cnt_q <= '0;
      cnt_q     <= '0;
    end else begin
      if (upd)               psc_sh_q <= psc_pre_i;
      if (upd || !prd_buf_i) prd_sh_q <= prd_pre_i;
      if (upd || tick)       psc_cnt_q <= '0;
      else if (en_i)         psc_cnt_q <= psc_cnt_q + 1'b1;
      if (ug_i || ovf)       cnt_q <= '0;
      else if (tick)         cnt_q <= cnt_q + 1'b1;
    end
  end

  assign cnt_o     = cnt_q;
  assign evt_o.ovf = ovf;
  assign evt_o.upd = upd;

  a_r12_freeze: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!en_i && !ug_i) |=> ($stable(cnt_q) && $stable(psc_cnt_q)));
  a_r9_force_clears: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ug_i |=> (cnt_q == '0 && psc_cnt_q == '0));
  a_r7_wrap_to_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ovf |=> cnt_q == '0);
  a_r8_psc_held: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !upd |=> $stable(psc_sh_q));
  a_r4_prd_held: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (prd_buf_i && !upd) |=> $stable(prd_sh_q));
endmodule

// File: rtl/dbuf_cmp_ch.sv
module dbuf_cmp_ch #(
  parameter int unsigned CW = 16
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          upd_i,
  input  logic          buf_i,
  input  logic [CW-1:0] cmp_pre_i,
  input  logic [CW-1:0] cnt_i,
  output logic          pwm_o
);
  logic [CW-1:0] cmp_sh_q, cmp_eff;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)              cmp_sh_q <= '0;
    else if (upd_i || !buf_i) cmp_sh_q <= cmp_pre_i;
  end

  assign cmp_eff = buf_i ? cmp_sh_q : cmp_pre_i;
  assign pwm_o   = cnt_i < cmp_eff;

  a_r5_buffered_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (buf_i && !upd_i) |=> $stable(cmp_sh_q));
  a_r6_commit_on_update: assert property (@(posedge clk_i) disable iff (!rst_ni)
    upd_i |=> cmp_sh_q == $past(cmp_pre_i));
endmodule

// File: rtl/dbuf_pwm_timer.sv
module dbuf_pwm_timer
  import dbuf_pwm_pkg::*;
#(
  parameter int unsigned CNT_W  = 16,
  parameter int unsigned NUM_CH = 2,
  parameter int unsigned ADDR_W = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              en_i,
  input  logic              bus_we_i,
  input  logic [ADDR_W-1:0] bus_addr_i,
  input  logic [CNT_W-1:0]  bus_wdata_i,
  output logic [CNT_W-1:0]  bus_rdata_o,
  output logic [NUM_CH-1:0] pwm_o,
  output logic              upd_flag_o
);
  logic                         ug, prd_buf;
  logic [NUM_CH-1:0]            cmp_buf;
  logic [CNT_W-1:0]             psc_pre, prd_pre, cnt;
  logic [NUM_CH-1:0][CNT_W-1:0] cmp_pre;
  tmr_evt_t                     evt;

  dbuf_regs #(.DW(CNT_W), .NUM_CH(NUM_CH), .AW(ADDR_W)) u_regs (
    .clk_i, .rst_ni,
    .we_i(bus_we_i), .addr_i(bus_addr_i), .wdata_i(bus_wdata_i), .rdata_o(bus_rdata_o),
    .upd_i(evt.upd), .ug_o(ug), .flag_o(upd_flag_o),
    .prd_buf_o(prd_buf), .cmp_buf_o(cmp_buf),
    .psc_pre_o(psc_pre), .prd_pre_o(prd_pre), .cmp_pre_o(cmp_pre)
  );

  dbuf_counter #(.CW(CNT_W)) u_counter (
    .clk_i, .rst_ni, .en_i, .ug_i(ug), .prd_buf_i(prd_buf),
    .psc_pre_i(psc_pre), .prd_pre_i(prd_pre), .cnt_o(cnt), .evt_o(evt)
  );

  for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
    dbuf_cmp_ch #(.CW(CNT_W)) u_ch (
      .clk_i, .rst_ni, .upd_i(evt.upd), .buf_i(cmp_buf[c]),
      .cmp_pre_i(cmp_pre[c]), .cnt_i(cnt), .pwm_o(pwm_o[c])
    );
  end
endmodule

// File: tb/dbuf_pwm_timer_bench.sv
`timescale 1ns/1ps
module dbuf_pwm_timer_bench;
  localparam int CW = 16;
  localparam int NC = 2;
  localparam int AW = 4;
  localparam int A_CTRL = 0, A_FLAG = 1, A_EVT = 2, A_PSC = 3, A_PRD = 4, A_CMP0 = 5;
  localparam int K_RD = 0, K_IRQ = 1, K_PWM = 2;

  typedef struct {
    string tag;
    int    kind;
    int    ch;
    int    arg;
    int    exp;
  } item_t;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          en = 1'b0;
  logic          we = 1'b0;
  logic [AW-1:0] addr = '0;
  logic [CW-1:0] wdata = '0;
  logic [CW-1:0] rdata;
  logic [NC-1:0] pwm;
  logic          upd_flag;

  int    n_checks = 0;
  int    n_fail = 0;
  bit    finished = 1'b0;
  item_t q[$];

  always #2.5 clk = ~clk;

  dbuf_pwm_timer #(.CNT_W(CW), .NUM_CH(NC), .ADDR_W(AW)) u_dbuf_pwm_timer (
    .clk_i(clk), .rst_ni(rst_n), .en_i(en),
    .bus_we_i(we), .bus_addr_i(addr), .bus_wdata_i(wdata), .bus_rdata_o(rdata),
    .pwm_o(pwm), .upd_flag_o(upd_flag)
  );

  task automatic check(input string tag, input int act, input int exp);
    n_checks++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic report();
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  endtask

  // driver side
  task automatic push(input string tag, input int kind, input int ch, input int arg, input int exp);
    item_t it;
    it.tag = tag; it.kind = kind; it.ch = ch; it.arg = arg; it.exp = exp;
    q.push_back(it);
  endtask

  task automatic drain();
    while (q.size() != 0) @(negedge clk);
  endtask

  task automatic wr(input int a, input int d);
    @(posedge clk); #1;
    we = 1'b1; addr = AW'(a); wdata = CW'(d);
    @(posedge clk); #1;
    we = 1'b0;
  endtask

  task automatic rd(input int a, input int exp, input string tag);
    @(posedge clk); #1;
    addr = AW'(a);
    push(tag, K_RD, 0, 1, exp);
    drain();
  endtask

  task automatic set_en(input logic v);
    @(posedge clk); #1;
    en = v;
  endtask

  // monitor side
  initial begin
    item_t it;
    int    act;
    forever begin
      @(negedge clk);
      if (q.size() != 0) begin
        it  = q[0];
        act = 0;
        case (it.kind)
          K_RD:    act = int'(rdata);
          K_IRQ:   act = int'(upd_flag);
          default: begin
            for (int i = 0; i < it.arg; i++) begin
              if (i > 0) @(negedge clk);
              act += int'(pwm[it.ch]);
            end
          end
        endcase
        q.delete(0);
        check(it.tag, act, it.exp);
      end
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      n_checks++;
      n_fail++;
      $display("FAIL watchdog: actual 0 expected 1 (run did not complete)");
      report();
    end
  end

  initial begin
    #12 rst_n = 1'b1;

    // R1 reset state
    rd(A_CTRL, 0, "R1 ctrl");
    rd(A_PRD, 0, "R1 period");
    rd(A_CMP0, 0, "R1 compare0");
    rd(A_PSC, 0, "R1 prescaler");
    push("R1 flag", K_IRQ, 0, 1, 0);
    push("R1 pwm0 low", K_PWM, 0, 1, 0);
    drain();

    // unbuffered period and compares
    wr(A_PRD, 9);
    wr(A_CMP0, 5);
    wr(A_CMP0 + 1, 2);
    rd(A_PRD, 9, "R2 period readback");
    wr(A_EVT, 1);
    set_en(1'b1);
    push("R11 ch0 duty 5/10", K_PWM, 0, 10, 5);
    push("R5 ch1 unbuffered duty 2/10", K_PWM, 1, 10, 2);
    drain();
    wr(A_PRD, 4);
    push("R3 immediate period 5", K_PWM, 1, 10, 4);
    drain();

    // buffered period and ch0 compare
    set_en(1'b0);
    wr(A_CTRL, 3);
    wr(A_PRD, 9);
    wr(A_CMP0, 5);
    wr(A_EVT, 1);
    push("R9 forced update sets flag", K_IRQ, 0, 1, 1);
    drain();
    wr(A_FLAG, 1);
    push("R10 write one keeps flag", K_IRQ, 0, 1, 1);
    drain();
    wr(A_FLAG, 0);
    push("R10 write zero clears flag", K_IRQ, 0, 1, 0);
    drain();
    rd(A_FLAG, 0, "R10 flag register");
    rd(A_CTRL, 3, "R2 ctrl readback");
    wr(A_CMP0, 0);
    push("R5 buffered compare held", K_PWM, 0, 1, 1);
    drain();
    wr(A_PRD, 3);
    rd(A_PRD, 3, "R2 staged period readback");
    wr(A_CMP0, 2);
    wr(A_CMP0 + 1, 0);
    push("R5 unbuffered compare immediate low", K_PWM, 1, 1, 0);
    drain();
    wr(A_CMP0 + 1, 3);
    push("R5 unbuffered compare immediate high", K_PWM, 1, 1, 1);
    drain();
    set_en(1'b1);
    push("R4 old period held until wrap", K_PWM, 0, 10, 5);
    push("R6 period and compare commit together", K_PWM, 0, 8, 4);
    drain();
    push("R7 wrap sets flag", K_IRQ, 0, 1, 1);
    drain();

    // R12 enable low freezes count
    set_en(1'b0);
    wr(A_EVT, 1);
    push("R12 frozen count keeps pwm1 high", K_PWM, 1, 6, 6);
    drain();

    // prescaler
    wr(A_CTRL, 0);
    wr(A_PRD, 4);
    wr(A_CMP0, 2);
    wr(A_EVT, 1);
    wr(A_PSC, 1);
    rd(A_PSC, 1, "R2 prescaler readback");
    set_en(1'b1);
    push("R8 prescaler held until update", K_PWM, 0, 5, 2);
    push("R8 divide by two after update", K_PWM, 0, 10, 4);
    drain();
    wr(A_EVT, 1);
    push("R9 forced update clears prescaler count", K_PWM, 0, 6, 4);
    drain();
    rd(A_EVT, 0, "R2 event reads zero");

    finished = 1'b1;
    report();
  end
endmodule